// File: doc/BRIEF.md
# Pipelined Bus Slave Cycle Sequencer

This block follows the bus cycles that a host processor runs against a coprocessor-style slave. It samples the host's address strobe, chip select, ready and read/write line on every clock. From these it generates a write-data latch strobe, a read-data drive enable, a one-clock cycle-complete pulse and its current state. It handles plain cycles that return to idle after each transfer. It also handles address-pipelined cycles, in which the host issues the next address strobe in the same clock that ready ends the current transfer.

The machine has three states. Idle waits for a selected address strobe. Sample holds the cycle open and watches ready; it stays there for any number of wait states. Pipe lasts one clock and is entered when a new selected strobe coincides with ready. Ending a transfer by entering pipe has the same effect as ending it by returning to idle: the transfer completes and the data bus is released. Pipe always hands control back to sample, so a run of pipelined cycles moves between sample and pipe only.

The block never delays ready; any wait states come from outside logic. The bus_state encoding is 0 = idle, 1 = sample, 2 = pipe. The block has no streaming data path, so it uses no valid/ready handshake: bus_ready is the host bus ready, not back-pressure.

Top module: `bus_slave_seq`

## Requirements
- R1: While rst is high (synchronous, active high), the clock edge puts bus_state at 0 (idle) and wdata_latch, rdata_oe and cycle_done are all low, whatever the other inputs do.
- R2: In idle, a clock edge that samples adr_strobe=1 together with chip_sel=1 moves bus_state to 1 (sample). A strobe without chip_sel, or chip_sel without a strobe, leaves the machine in idle.
- R3: In sample, every clock edge that samples bus_ready=0 keeps bus_state at 1 and produces no cycle_done pulse (wait state).
- R4: In sample, an edge that samples bus_ready=1 without a selected strobe moves bus_state to 0. cycle_done is high for exactly the one following clock.
- R5: In sample, an edge that samples bus_ready=1 together with adr_strobe=1 and chip_sel=1 moves bus_state to 2 (pipe). cycle_done is high for the one following clock, just as for a return to idle.
- R6: Pipe lasts exactly one clock, and bus_state then returns to 1 whatever the inputs are.
- R7: wdata_latch is high exactly while bus_state is 1, the open cycle is a write (wr_nrd=1 at its start), and bus_ready=1. The data is therefore taken on the edge that samples ready.
- R8: rdata_oe is high exactly while bus_state is 1 and the open cycle is a read (wr_nrd=0 at its start). It is low in idle and in pipe.
- R9: The cycle direction is captured from wr_nrd on the edge that starts the cycle (from idle or on the pipelined overlap). A change on wr_nrd later in the cycle has no effect on the outputs.
- R10: A chain of back-to-back pipelined cycles passes only through states 1 and 2 and never visits idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adr_strobe | input | 1 | Host address strobe, active high |
| bus_ready | input | 1 | Host bus ready, active high |
| chip_sel | input | 1 | Slave select qualifying the strobe |
| wr_nrd | input | 1 | Direction, 1 = write, 0 = read |
| wdata_latch | output | 1 | Write data capture strobe |
| rdata_oe | output | 1 | Read data drive enable |
| cycle_done | output | 1 | One-clock pulse after each completed transfer |
| bus_state | output | 2 | Current state: 0 idle, 1 sample, 2 pipe |

## Verification
On every clock, the assertions check four things: that pipe always returns to sample after one clock, that a wait state holds sample, that a selected strobe in idle opens a cycle, and that the captured direction stays fixed while sample lasts. They also check that cycle_done never lasts two clocks and that the latch strobe and the drive enable are never high together. The bench's scenarios are what show the exact levels of the outputs in each state. They also show that unselected strobes and mid-cycle direction changes are ignored, and that a chain of pipelined cycles with mixed directions never touches idle.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_PIPE   = 2'd2
  } bus_st_e;

endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    strobe,
  input  logic    sel,
  input  logic    ready,
  output bus_st_e state,
  output logic    launch,
  output logic    finish
);

  bus_st_e nxt;
  logic    req;

  assign req = strobe & sel;

  // a cycle opens from idle or on the pipelined overlap
  assign launch = ((state == ST_IDLE) & req) | ((state == ST_SAMPLE) & ready & req);
  assign finish = (state == ST_SAMPLE) & ready;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (req) nxt = ST_SAMPLE;
      ST_SAMPLE: if (ready) nxt = req ? ST_PIPE : ST_IDLE;
      ST_PIPE:   nxt = ST_SAMPLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  AST_PIPE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    state == ST_PIPE |=> state == ST_SAMPLE);                       // R6
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SAMPLE && !ready) |=> state == ST_SAMPLE);          // R3
  AST_IDLE_OPENS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && strobe && sel) |=> state == ST_SAMPLE);     // R2

endmodule

// File: rtl/bus_seq_dir.sv
module bus_seq_dir
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  logic    wr_in,
  input  bus_st_e state,
  output logic    is_wr
);

  always_ff @(posedge clk) begin
    if (rst)       is_wr <= 1'b0;
    else if (load) is_wr <= wr_in;
  end

  AST_DIR_FIXED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SAMPLE && $past(state) == ST_SAMPLE) |-> $stable(is_wr)); // R9

endmodule

// File: rtl/bus_seq_out.sv
module bus_seq_out
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  bus_st_e state,
  input  logic    ready,
  input  logic    is_wr,
  input  logic    finish,
  output logic    latch,
  output logic    drive,
  output logic    done
);

  logic in_sample;

  assign in_sample = (state == ST_SAMPLE);
  assign latch     = ~rst & in_sample & ready & is_wr;
  assign drive     = ~rst & in_sample & ~is_wr;

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= finish;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                 // R4
  AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (rst)
    !(latch && drive));                                              // R8

endmodule

// File: rtl/bus_slave_seq.sv
module bus_slave_seq
  import bus_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            adr_strobe,
  input  logic            bus_ready,
  input  logic            chip_sel,
  input  logic            wr_nrd,
  output logic            wdata_latch,
  output logic            rdata_oe,
  output logic            cycle_done,
  output logic [ST_W-1:0] bus_state
);

  bus_st_e st;
  logic    launch;
  logic    finish;
  logic    is_wr;

  bus_seq_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .strobe (adr_strobe),
    .sel    (chip_sel),
    .ready  (bus_ready),
    .state  (st),
    .launch (launch),
    .finish (finish)
  );

  bus_seq_dir u_dir (
    .clk   (clk),
    .rst   (rst),
    .load  (launch),
    .wr_in (wr_nrd),
    .state (st),
    .is_wr (is_wr)
  );

  bus_seq_out u_out (
    .clk    (clk),
    .rst    (rst),
    .state  (st),
    .ready  (bus_ready),
    .is_wr  (is_wr),
    .finish (finish),
    .latch  (wdata_latch),
    .drive  (rdata_oe),
    .done   (cycle_done)
  );

  assign bus_state = st;

endmodule

// File: tb/bus_slave_seq_test.sv
module bus_slave_seq_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       adr_strobe, bus_ready, chip_sel, wr_nrd;
  logic       wdata_latch, rdata_oe, cycle_done;
  logic [1:0] bus_state;

  int total = 0;
  int bad   = 0;
  logic pre_latch, pre_oe;

  always #5 clk = ~clk;

  bus_slave_seq uut (
    .clk(clk), .rst(rst), .adr_strobe(adr_strobe), .bus_ready(bus_ready),
    .chip_sel(chip_sel), .wr_nrd(wr_nrd), .wdata_latch(wdata_latch),
    .rdata_oe(rdata_oe), .cycle_done(cycle_done), .bus_state(bus_state)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // drive inputs after an edge, record outputs before the next edge, step
  task automatic cyc(input logic as, input logic rdy, input logic cs, input logic wr);
    adr_strobe = as; bus_ready = rdy; chip_sel = cs; wr_nrd = wr;
    #2;
    pre_latch = wdata_latch;
    pre_oe    = rdata_oe;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc(1, 1, 1, 1);
    cyc(1, 1, 1, 0);
    chk("R1 state", bus_state, 0);
    chk("R1 latch", wdata_latch, 0);
    chk("R1 oe", rdata_oe, 0);
    chk("R1 done", cycle_done, 0);
    rst = 1'b0;
    cyc(0, 0, 0, 0);
  endtask

  task automatic t_unselected();
    cyc(1, 0, 0, 1);
    chk("R2 strobe without select", bus_state, 0);
    cyc(0, 0, 1, 1);
    chk("R2 select without strobe", bus_state, 0);
  endtask

  task automatic t_read_waits();
    cyc(1, 0, 1, 0);
    chk("R2 open", bus_state, 1);
    cyc(0, 0, 0, 1);                // wait state, direction line flips
    chk("R8 oe in read", pre_oe, 1);
    chk("R9 no latch after flip", pre_latch, 0);
    chk("R3 hold", bus_state, 1);
    chk("R3 no done", cycle_done, 0);
    cyc(0, 0, 0, 1);
    chk("R3 hold again", bus_state, 1);
    cyc(0, 1, 0, 1);
    chk("R9 oe stays read", pre_oe, 1);
    chk("R9 latch stays low", pre_latch, 0);
    chk("R4 to idle", bus_state, 0);
    chk("R4 done", cycle_done, 1);
    cyc(0, 0, 0, 0);
    chk("R4 done one clock", cycle_done, 0);
    chk("R8 oe low in idle", pre_oe, 0);
  endtask

  task automatic t_write_zero_wait();
    cyc(1, 0, 1, 1);
    chk("R2 open write", bus_state, 1);
    cyc(0, 1, 0, 0);
    chk("R7 latch", pre_latch, 1);
    chk("R8 oe low on write", pre_oe, 0);
    chk("R4 idle", bus_state, 0);
    chk("R4 done", cycle_done, 1);
    cyc(0, 0, 0, 0);
    chk("R4 done cleared", cycle_done, 0);
  endtask

  task automatic t_pipeline();
    int seen_idle = 0;
    cyc(1, 0, 1, 1);                // write opens
    cyc(1, 1, 1, 0);                // ready with overlap strobe for a read
    chk("R7 latch on overlap", pre_latch, 1);
    chk("R5 to pipe", bus_state, 2);
    chk("R5 done", cycle_done, 1);
    cyc(1, 1, 1, 1);                // inputs ignored in pipe
    chk("R8 oe low in pipe", pre_oe, 0);
    chk("R7 latch low in pipe", pre_latch, 0);
    chk("R6 back to sample", bus_state, 1);
    chk("R6 done cleared", cycle_done, 0);
    if (bus_state == 0) seen_idle++;
    cyc(1, 1, 1, 1);                // read ends, write overlaps
    chk("R9 overlap read direction", pre_oe, 1);
    chk("R5 pipe again", bus_state, 2);
    if (bus_state == 0) seen_idle++;
    cyc(0, 0, 0, 0);
    chk("R6 sample again", bus_state, 1);
    if (bus_state == 0) seen_idle++;
    cyc(0, 1, 0, 0);
    chk("R7 latch for pipelined write", pre_latch, 1);
    chk("R10 no idle in chain", seen_idle, 0);
    chk("R4 end of chain", bus_state, 0);
  endtask

  initial begin
    adr_strobe = 0; bus_ready = 0; chip_sel = 0; wr_nrd = 0; rst = 1;
    t_reset();
    t_unselected();
    t_read_waits();
    t_write_zero_wait();
    t_pipeline();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog got=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule